// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept and, if so, which receive buffer takes it. When a frame-valid strobe arrives, the frame's identifier, its IDE flag and its RTR flag are compared against a reference identifier held for each of the message buffers. Each buffer is configured as enabled or disabled, receive or transmit, and busy or free. Only an enabled, free receive buffer may take a frame.

Every ordinary buffer is compared through one shared global acceptance mask. A mask bit of 1 forces the identifier bit to match. A mask bit of 0 makes that bit don't-care, so one buffer can take a single identifier or a whole group of them. One designated buffer is compared through its own independent mask instead of the global one. With that mask cleared, it becomes a catch-all path for frames that no ordinary buffer takes.

The verdict is registered. It comes out one clock after the strobe as a valid pulse, a hit flag and the index of the winning buffer. The surrounding receive logic uses these to steer the frame's storage.

Top module: `can_acc_filter`

## Requirements
- R1: For a standard frame (IDE=0), only identifier bits 10:0 are compared; bits 28:11 of the frame and of the buffer reference have no effect.
- R2: For an extended frame (IDE=1), all 29 identifier bits are compared.
- R3: The frame's IDE flag must equal the buffer's IDE flag, whatever the masks hold, so a standard frame never lands in an extended buffer and the reverse.
- R4: For every buffer except the designated one, global mask bit n set to 1 requires identifier bit n to equal the buffer's reference bit n; a 0 makes that bit don't-care.
- R5: The designated buffer (index BASIC_IDX) is compared through its own mask and RTR-mask bit, and the global mask has no effect on it.
- R6: A buffer can take a frame only if its enable bit is 1, its receive bit is 1 (0 means transmit) and its busy bit is 0.
- R7: When several ordinary buffers qualify, the lowest-numbered one wins; the designated buffer is chosen only when no ordinary buffer qualifies, whatever its index.
- R8: Each mask carries an RTR-mask bit; when it is 1, the frame's RTR flag must equal the buffer's reference RTR bit, and when it is 0, RTR is don't-care.
- R9: out_vld is 1 exactly one clock after a cycle with frm_vld=1. out_hit and out_idx give that frame's verdict in the same cycle. out_idx is 0 whenever out_hit is 0, and out_hit is 0 whenever out_vld is 0.
- R10: Synchronous active-high reset drives out_vld, out_hit and out_idx to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | One-cycle strobe: a received identifier is present |
| frm_id | input | ID_W | Received identifier (standard identifier in bits 10:0) |
| frm_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| frm_rtr | input | 1 | 1 = remote frame |
| glb_mask | input | ID_W | Global acceptance mask, 1 = bit must match |
| glb_mask_rtr | input | 1 | Global RTR-mask bit |
| bas_mask | input | ID_W | Mask of the designated buffer |
| bas_mask_rtr | input | 1 | RTR-mask bit of the designated buffer |
| buf_id | input | NUM_BUF*ID_W | Reference identifiers, buffer i in bits i*ID_W +: ID_W |
| buf_ide | input | NUM_BUF | Reference IDE flag for each buffer |
| buf_rtr | input | NUM_BUF | Reference RTR flag for each buffer |
| buf_en | input | NUM_BUF | Buffer enable |
| buf_rx | input | NUM_BUF | 1 = receive buffer, 0 = transmit buffer |
| buf_busy | input | NUM_BUF | Buffer currently busy |
| out_vld | output | 1 | Verdict valid, one clock after frm_vld |
| out_hit | output | 1 | Frame accepted |
| out_idx | output | IDX_W | Index of the accepting buffer |

## Verification
The bench builds the filter with fifteen 29-bit buffers and places the designated buffer at index 2 instead of the default top index. Because buffers both above and below it compete, a design that ranks the designated buffer by its index instead of by its fallback role is caught. Fifteen buffers also fill all but one code of the 4-bit index, so an index range check covers a realistic encoding.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int STD_ID_W = 11;
  localparam int EXT_ID_W = 29;
endpackage

// File: rtl/can_id_cmp.sv
module can_id_cmp
  import can_acc_pkg::*;
#(
  parameter int ID_W = EXT_ID_W
) (
  input  logic [ID_W-1:0] id_in,
  input  logic            ide_in,
  input  logic            rtr_in,
  input  logic [ID_W-1:0] ref_id,
  input  logic            ref_ide,
  input  logic            ref_rtr,
  input  logic [ID_W-1:0] mask_id,
  input  logic            mask_rtr,
  output logic            match
);
  localparam int UPPER_W = ID_W - STD_ID_W;

  logic [ID_W-1:0] keep;
  logic [ID_W-1:0] diff;
  logic            rtr_ok;

  // extended frames compare every bit, standard frames only the low field
  assign keep   = ide_in ? {ID_W{1'b1}} : {{UPPER_W{1'b0}}, {STD_ID_W{1'b1}}};
  assign diff   = (id_in ^ ref_id) & mask_id & keep;
  assign rtr_ok = !mask_rtr || (rtr_in == ref_rtr);
  assign match  = (ide_in == ref_ide) && (diff == '0) && rtr_ok;
endmodule

// File: rtl/can_first_pick.sv
module can_first_pick #(
  parameter int NUM_BUF   = 15,
  parameter int BASIC_IDX = 14,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_BUF-1:0] cand,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    // walk downward so the lowest-numbered ordinary candidate is kept last
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (i != BASIC_IDX && cand[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    if (!hit && cand[BASIC_IDX]) begin
      hit = 1'b1;
      idx = IDX_W'(BASIC_IDX);
    end
  end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_acc_pkg::*;
#(
  parameter int NUM_BUF   = 15,
  parameter int ID_W      = EXT_ID_W,
  parameter int BASIC_IDX = NUM_BUF - 1,
  localparam int IDX_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frm_vld,
  input  logic [ID_W-1:0]         frm_id,
  input  logic                    frm_ide,
  input  logic                    frm_rtr,
  input  logic [ID_W-1:0]         glb_mask,
  input  logic                    glb_mask_rtr,
  input  logic [ID_W-1:0]         bas_mask,
  input  logic                    bas_mask_rtr,
  input  logic [NUM_BUF*ID_W-1:0] buf_id,
  input  logic [NUM_BUF-1:0]      buf_ide,
  input  logic [NUM_BUF-1:0]      buf_rtr,
  input  logic [NUM_BUF-1:0]      buf_en,
  input  logic [NUM_BUF-1:0]      buf_rx,
  input  logic [NUM_BUF-1:0]      buf_busy,
  output logic                    out_vld,
  output logic                    out_hit,
  output logic [IDX_W-1:0]        out_idx
);
  logic [NUM_BUF-1:0] id_match;
  logic [NUM_BUF-1:0] cand;
  logic               pick_hit;
  logic [IDX_W-1:0]   pick_idx;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    logic [ID_W-1:0] sel_mask;
    logic            sel_mask_rtr;
    if (g == BASIC_IDX) begin : g_basic
      assign sel_mask     = bas_mask;
      assign sel_mask_rtr = bas_mask_rtr;
    end else begin : g_plain
      assign sel_mask     = glb_mask;
      assign sel_mask_rtr = glb_mask_rtr;
    end

    can_id_cmp #(.ID_W(ID_W)) cmp_i (
      .id_in   (frm_id),
      .ide_in  (frm_ide),
      .rtr_in  (frm_rtr),
      .ref_id  (buf_id[g*ID_W +: ID_W]),
      .ref_ide (buf_ide[g]),
      .ref_rtr (buf_rtr[g]),
      .mask_id (sel_mask),
      .mask_rtr(sel_mask_rtr),
      .match   (id_match[g])
    );

    assign cand[g] = id_match[g] && buf_en[g] && buf_rx[g] && !buf_busy[g];
  end

  can_first_pick #(
    .NUM_BUF  (NUM_BUF),
    .BASIC_IDX(BASIC_IDX),
    .IDX_W    (IDX_W)
  ) pick_i (
    .cand(cand),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_hit <= 1'b0;
      out_idx <= '0;
    end else begin
      out_vld <= frm_vld;
      out_hit <= frm_vld && pick_hit;
      out_idx <= (frm_vld && pick_hit) ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
  parameter int NUM_BUF = 15,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               frm_vld,
  input logic               frm_ide,
  input logic [NUM_BUF-1:0] buf_ide,
  input logic [NUM_BUF-1:0] buf_en,
  input logic [NUM_BUF-1:0] buf_rx,
  input logic [NUM_BUF-1:0] buf_busy,
  input logic               out_vld,
  input logic               out_hit,
  input logic [IDX_W-1:0]   out_idx
);
  logic [NUM_BUF-1:0] prev_ready;
  logic [NUM_BUF-1:0] prev_bide;
  logic               prev_fide;

  always_ff @(posedge clk) begin
    prev_ready <= buf_en & buf_rx & ~buf_busy;
    prev_bide  <= buf_ide;
    prev_fide  <= frm_ide;
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    frm_vld |=> out_vld);  // R9
  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> (!out_vld && !out_hit));  // R9
  AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    !out_hit |-> (out_idx == '0));  // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (int'(out_idx) < NUM_BUF));  // R7
  AST_HIT_READY_BUF: assert property (@(posedge clk) disable iff (rst)
    (out_hit && int'(out_idx) < NUM_BUF) |-> prev_ready[out_idx]);  // R6
  AST_IDE_EXACT: assert property (@(posedge clk) disable iff (rst)
    (out_hit && int'(out_idx) < NUM_BUF) |-> (prev_bide[out_idx] == prev_fide));  // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_vld && !out_hit && out_idx == '0));  // R10
endmodule

bind can_acc_filter can_acc_filter_chk #(
  .NUM_BUF(NUM_BUF),
  .IDX_W  (IDX_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .frm_vld (frm_vld),
  .frm_ide (frm_ide),
  .buf_ide (buf_ide),
  .buf_en  (buf_en),
  .buf_rx  (buf_rx),
  .buf_busy(buf_busy),
  .out_vld (out_vld),
  .out_hit (out_hit),
  .out_idx (out_idx)
);

// File: tb/can_acc_filter_tb_top.sv
`timescale 1ns/1ps
module can_acc_filter_tb_top;
  localparam int NB   = 15;
  localparam int IW   = 29;
  localparam int BI   = 2;
  localparam int XW   = 4;
  localparam int NVEC = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frm_vld = 1'b0;
  logic [IW-1:0]     frm_id = '0;
  logic              frm_ide = 1'b0;
  logic              frm_rtr = 1'b0;
  logic [IW-1:0]     glb_mask = '0;
  logic              glb_mask_rtr = 1'b0;
  logic [IW-1:0]     bas_mask = '0;
  logic              bas_mask_rtr = 1'b0;
  logic [NB*IW-1:0]  buf_id = '0;
  logic [NB-1:0]     buf_ide = '0;
  logic [NB-1:0]     buf_rtr = '0;
  logic [NB-1:0]     buf_en = '0;
  logic [NB-1:0]     buf_rx = '0;
  logic [NB-1:0]     buf_busy = '0;
  logic              out_vld;
  logic              out_hit;
  logic [XW-1:0]     out_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  can_acc_filter #(.NUM_BUF(NB), .ID_W(IW), .BASIC_IDX(BI)) dut_i (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_id(frm_id),
    .frm_ide(frm_ide), .frm_rtr(frm_rtr), .glb_mask(glb_mask),
    .glb_mask_rtr(glb_mask_rtr), .bas_mask(bas_mask),
    .bas_mask_rtr(bas_mask_rtr), .buf_id(buf_id), .buf_ide(buf_ide),
    .buf_rtr(buf_rtr), .buf_en(buf_en), .buf_rx(buf_rx),
    .buf_busy(buf_busy), .out_vld(out_vld), .out_hit(out_hit),
    .out_idx(out_idx)
  );

  // vector: {id, ide, rtr, exp_hit, exp_idx}
  localparam logic [IW+XW+2:0] VEC [NVEC] = '{
    {29'h0000123, 1'b0, 1'b0, 1'b1, 4'd0},  // R7 buf0 over buf1 and basic
    {29'h000012A, 1'b0, 1'b0, 1'b1, 4'd0},  // R4 don't-care nibble
    {29'h0000133, 1'b0, 1'b0, 1'b1, 4'd2},  // R4 R5 masked bit differs
    {29'h1ABCDE07, 1'b1, 1'b0, 1'b1, 4'd3}, // R2 extended group
    {29'h1ABCDF00, 1'b1, 1'b0, 1'b0, 4'd0}, // R2 R3 miss everywhere
    {29'h0000123, 1'b1, 1'b0, 1'b1, 4'd5},  // R3 extended twin of buf0
    {29'h0000200, 1'b0, 1'b1, 1'b1, 4'd4},  // R8 remote match
    {29'h0000200, 1'b0, 1'b0, 1'b1, 4'd2},  // R8 RTR differs, basic ignores
    {29'h0000123, 1'b0, 1'b1, 1'b1, 4'd2},  // R8 remote vs data buffers
    {29'h0000300, 1'b0, 1'b0, 1'b1, 4'd2},  // R6 disabled
    {29'h0000310, 1'b0, 1'b0, 1'b1, 4'd2},  // R6 transmit buffer
    {29'h0000320, 1'b0, 1'b0, 1'b1, 4'd2},  // R6 busy
    {29'h1FFFF330, 1'b0, 1'b0, 1'b1, 4'd9}  // R1 upper bits ignored
  };

  task automatic set_buf(input int i, input logic [IW-1:0] id, input logic ide,
                         input logic rtr, input logic en, input logic rx,
                         input logic busy);
    buf_id[i*IW +: IW] = id;
    buf_ide[i]  = ide;
    buf_rtr[i]  = rtr;
    buf_en[i]   = en;
    buf_rx[i]   = rx;
    buf_busy[i] = busy;
  endtask

  task automatic check(input string req, input logic [XW+1:0] act,
                       input logic [XW+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s vld/hit/idx actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one frame, sample the registered verdict one clock later
  task automatic send(input logic [IW-1:0] id, input logic ide, input logic rtr,
                      input string req, input logic hit, input logic [XW-1:0] idx);
    @(negedge clk);
    frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_vld = 1'b1;
    @(negedge clk);
    frm_vld = 1'b0;
    check(req, {out_vld, out_hit, out_idx}, {1'b1, hit, idx});
  endtask

  initial begin
    glb_mask = 29'h1FFFFFF0; glb_mask_rtr = 1'b1;
    bas_mask = '0;           bas_mask_rtr = 1'b0;
    set_buf(0, 29'h123, 0, 0, 1, 1, 0);
    set_buf(1, 29'h123, 0, 0, 1, 1, 0);
    set_buf(BI, 29'h000, 0, 0, 1, 1, 0);
    set_buf(3, 29'h1ABCDE00, 1, 0, 1, 1, 0);
    set_buf(4, 29'h200, 0, 1, 1, 1, 0);
    set_buf(5, 29'h123, 1, 0, 1, 1, 0);
    set_buf(6, 29'h300, 0, 0, 0, 1, 0);
    set_buf(7, 29'h310, 0, 0, 1, 0, 0);
    set_buf(8, 29'h320, 0, 0, 1, 1, 1);
    set_buf(9, 29'h330, 0, 0, 1, 1, 0);

    // R10 reset state, with a strobe held during reset
    frm_vld = 1'b1; frm_id = 29'h123;
    repeat (3) @(negedge clk);
    check("R10", {out_vld, out_hit, out_idx}, '0);
    frm_vld = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10", {out_vld, out_hit, out_idx}, '0);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][IW+XW+2:XW+3], VEC[v][XW+2], VEC[v][XW+1],
           $sformatf("R1-vec%0d", v), VEC[v][XW], VEC[v][XW-1:0]);
    end

    // R9 no strobe: matching identifier present but nothing reported
    @(negedge clk);
    frm_id = 29'h123; frm_ide = 1'b0; frm_rtr = 1'b0;
    @(negedge clk);
    check("R9", {out_vld, out_hit, out_idx}, '0);

    // R9 verdict lasts exactly one cycle
    send(29'h123, 0, 0, "R9", 1'b1, 4'd0);
    @(negedge clk);
    check("R9", {out_vld, out_hit, out_idx}, '0);

    // R6 R7 busy lowest buffer passes to next ordinary one
    buf_busy[0] = 1'b1;
    send(29'h123, 0, 0, "R7", 1'b1, 4'd1);
    buf_busy[0] = 1'b0;

    // R5 global mask tightened: ordinary miss, basic unaffected
    glb_mask = 29'h1FFFFFFF;
    send(29'h12A, 0, 0, "R5", 1'b1, 4'd2);
    // R4 full global mask now needs an exact match
    send(29'h123, 0, 0, "R4", 1'b1, 4'd0);
    // R5 basic uses its own mask
    bas_mask = 29'h1FFFFFFF;
    send(29'h001, 0, 0, "R5", 1'b0, 4'd0);
    send(29'h000, 0, 0, "R5", 1'b1, 4'd2);
    // R8 basic RTR mask enforced
    bas_mask_rtr = 1'b1;
    send(29'h000, 0, 1, "R8", 1'b0, 4'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule